// File: doc/BRIEF.md
# Write Leveling Edge Search

This block is a training sequencer for a DDR write path. It lines up the rising edge of the outgoing write strobe with the memory clock as that clock arrives at the DRAM. While it runs, the DRAM is in its write-leveling feedback mode. In that mode the DRAM samples its own clock on each rising strobe edge and returns the sampled value on a data pin.

The sequencer keeps the strobe toggling and steps the strobe output delay by one tap at a time, starting from zero. After each step it waits for the delay line to settle, then takes several samples of the returned feedback bit and reduces them to one value by a majority vote. The search ends on the first step whose vote is 1 when the vote of the step before it was 0. That tap is kept on the delay output as the aligned setting and done is raised. If the last tap is reached with no such rise, fail is raised and the delay is returned to zero.

This search has to finish before any of the guaranteed writes that later read-deskew training relies on are issued. Putting the DRAM into and out of its leveling mode, and the analog delay line itself, are handled outside this block.

Top module: `wlvl_edge_search`

## Requirements
- R1: Out of reset and while idle, `strobe_en_o` is 0. It goes to 1 in the cycle after a start is accepted and stays 1 until the search ends.
- R2: Each delay step takes SETTLE_CYC settle cycles, then N_SAMP feedback samples, then one decision cycle. `dly_o` starts at 0 and only ever grows by exactly one tap per step. With the defaults (4 and 8) a step lasts 13 cycles, so an edge found at tap T raises done 13*(T+1) cycles after the start edge.
- R3: A step reads as 1 only if at least VOTE_MIN of its N_SAMP samples are 1 (defaults 5 of 8). Four ones out of eight read as 0.
- R4: Done is raised when the previous step read 0 and the current step reads 1, and `dly_o` then holds the current tap. A 1 at tap 0, where no previous step exists, and a step from 1 to 1 or from 1 to 0 do not end the search.
- R5: If the step at the maximum tap (127 for a 7-bit delay) does not end the search, `fail_o` is raised and `dly_o` becomes 0. Done and fail are never both 1.
- R6: `strobe_en_o` is 0 from the cycle after done or fail is first raised, unless a new start is given.
- R7: A start pulse during a search has no effect. A start given while idle, done or failed begins a new search from tap 0 and clears done and fail.
- R8: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse to begin a search |
| fb_i | input | 1 | Memory clock level sampled by the DRAM on the strobe rising edge |
| strobe_en_o | output | 1 | Keeps the write strobe toggling while high |
| dly_o | output | TAP_W (7) | Strobe output delay tap |
| done_o | output | 1 | Aligned setting found and held on dly_o |
| fail_o | output | 1 | No rising edge found over the whole tap range |

## Verification
Three kinds of feedback are driven. A clean step at several thresholds, including tap 127, checks the edge position and the step timing. A pattern that is 1 at the start, drops to 0 and then rises again shows that only a true 0-to-1 rise counts. Feedback that is always 0, and feedback that is always 1 from tap 0, both run the search into the failure path. Period-eight noise patterns with four against five ones, and with two against seven ones, separate the vote threshold from the raw sample values. A start pulse given in the middle of a search shows whether the sequencer restarts or carries on.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [2:0] {
        WL_IDLE,
        WL_SETTLE,
        WL_SAMPLE,
        WL_EVAL,
        WL_DONE,
        WL_FAIL
    } wl_state_e;

    typedef struct packed {
        wl_state_e state;
        logic      strobe_en;
        logic      done;
        logic      fail;
    } wl_ctl_t;

endpackage

// File: rtl/wlvl_phase_timer.sv
module wlvl_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last_o = (tmr_q.cnt == lim_i);

endmodule

// File: rtl/wlvl_vote.sv
module wlvl_vote #(
    parameter int N_SAMP   = 8,
    parameter int VOTE_MIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic smp_i,
    input  logic bit_i,
    output logic vote_o
);

    localparam int ONES_W = $clog2(N_SAMP + 1);

    typedef struct packed {
        logic [ONES_W-1:0] ones;
    } vote_t;

    vote_t vt_d, vt_q;

    always_comb begin
        vt_d = vt_q;
        if (clr_i) begin
            vt_d.ones = '0;
        end else if (smp_i && bit_i) begin
            vt_d.ones = vt_q.ones + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vt_q <= '0;
        end else begin
            vt_q <= vt_d;
        end
    end

    assign vote_o = (vt_q.ones >= ONES_W'(VOTE_MIN));

    // R3: the count of ones can never exceed the sample window
    assert_ones_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vt_q.ones <= ONES_W'(N_SAMP));

    // R3: a cleared window always reads as 0 on the next cycle
    assert_clear_reads_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !vote_o);

endmodule

// File: rtl/wlvl_tap_track.sv
module wlvl_tap_track #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             zero_i,
    input  logic             vote_i,
    output logic [TAP_W-1:0] dly_o,
    output logic             at_max_o,
    output logic             prev_low_o
);

    typedef struct packed {
        logic [TAP_W-1:0] dly;
        logic             prev_val;
        logic             prev_known;
    } tap_t;

    tap_t tap_d, tap_q;

    always_comb begin
        tap_d = tap_q;
        if (clr_i) begin
            tap_d.dly        = '0;
            tap_d.prev_val   = 1'b0;
            tap_d.prev_known = 1'b0;
        end else if (zero_i) begin
            tap_d.dly = '0;
        end else if (step_i) begin
            tap_d.dly        = tap_q.dly + 1'b1;
            tap_d.prev_val   = vote_i;
            tap_d.prev_known = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign dly_o      = tap_q.dly;
    assign at_max_o   = &tap_q.dly;
    assign prev_low_o = tap_q.prev_known && !tap_q.prev_val;

    // R2: a step moves the delay up by exactly one tap
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !zero_i) |=> (dly_o - $past(dly_o)) == TAP_W'(1));

    // R2: a new search starts from tap 0 with no previous step
    assert_clear_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (dly_o == '0) && !prev_low_o);

endmodule

// File: rtl/wlvl_edge_search.sv
module wlvl_edge_search #(
    parameter int TAP_W      = 7,
    parameter int SETTLE_CYC = 4,
    parameter int N_SAMP     = 8,
    parameter int VOTE_MIN   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fb_i,
    output logic             strobe_en_o,
    output logic [TAP_W-1:0] dly_o,
    output logic             done_o,
    output logic             fail_o
);
    import wlvl_pkg::*;

    localparam int MAX_PH = (SETTLE_CYC > N_SAMP) ? SETTLE_CYC : N_SAMP;
    localparam int CNT_W  = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SAMP_LIM   = CNT_W'(N_SAMP - 1);

    wl_ctl_t ctl_d, ctl_q;

    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_lim;
    logic             tmr_last;
    logic             vote_clr;
    logic             vote_smp;
    logic             vote;
    logic             tap_clr;
    logic             tap_step;
    logic             tap_zero;
    logic             at_max;
    logic             prev_low;
    logic             busy;

    wlvl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .lim_i  (tmr_lim),
        .last_o (tmr_last)
    );

    wlvl_vote #(.N_SAMP(N_SAMP), .VOTE_MIN(VOTE_MIN)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (vote_clr),
        .smp_i  (vote_smp),
        .bit_i  (fb_i),
        .vote_o (vote)
    );

    wlvl_tap_track #(.TAP_W(TAP_W)) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tap_clr),
        .step_i     (tap_step),
        .zero_i     (tap_zero),
        .vote_i     (vote),
        .dly_o      (dly_o),
        .at_max_o   (at_max),
        .prev_low_o (prev_low)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_clr  = 1'b0;
        tmr_lim  = SETTLE_LIM;
        vote_clr = 1'b0;
        vote_smp = 1'b0;
        tap_clr  = 1'b0;
        tap_step = 1'b0;
        tap_zero = 1'b0;
        unique case (ctl_q.state)
            WL_IDLE, WL_DONE, WL_FAIL: begin
                ctl_d.strobe_en = 1'b0;
                if (start_i) begin
                    ctl_d.state     = WL_SETTLE;
                    ctl_d.strobe_en = 1'b1;
                    ctl_d.done      = 1'b0;
                    ctl_d.fail      = 1'b0;
                    tmr_clr         = 1'b1;
                    tap_clr         = 1'b1;
                end
            end
            WL_SETTLE: begin
                tmr_lim = SETTLE_LIM;
                if (tmr_last) begin
                    ctl_d.state = WL_SAMPLE;
                    tmr_clr     = 1'b1;
                    vote_clr    = 1'b1;
                end
            end
            WL_SAMPLE: begin
                tmr_lim  = SAMP_LIM;
                vote_smp = 1'b1;
                if (tmr_last) begin
                    ctl_d.state = WL_EVAL;
                end
            end
            WL_EVAL: begin
                if (prev_low && vote) begin
                    ctl_d.state = WL_DONE;
                    ctl_d.done  = 1'b1;
                end else if (at_max) begin
                    ctl_d.state = WL_FAIL;
                    ctl_d.fail  = 1'b1;
                    tap_zero    = 1'b1;
                end else begin
                    ctl_d.state = WL_SETTLE;
                    tap_step    = 1'b1;
                    tmr_clr     = 1'b1;
                end
            end
            default: begin
                ctl_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign strobe_en_o = ctl_q.strobe_en;
    assign done_o      = ctl_q.done;
    assign fail_o      = ctl_q.fail;
    assign busy        = (ctl_q.state == WL_SETTLE) || (ctl_q.state == WL_SAMPLE);

    // R1: no strobe activity while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == WL_IDLE) |-> !strobe_en_o);

    // R5: the two outcomes exclude each other
    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    // R5: a failed search leaves the delay at tap 0
    assert_fail_zero_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (dly_o == '0));

    // R4: the found setting does not drift while done is held
    assert_done_holds_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(dly_o));

    // R6: strobe stops one cycle after an outcome
    assert_stop_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || fail_o) && !start_i) |=> !strobe_en_o);

    // R7: a start during a search changes nothing visible
    assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> strobe_en_o && $stable(dly_o) && !done_o && !fail_o);

endmodule

// File: tb/wlvl_edge_search_tb.sv
module wlvl_edge_search_tb_top;

    localparam int TAP_W  = 7;
    localparam int SETTLE = 4;
    localparam int NS     = 8;
    localparam int VMIN   = 5;
    localparam int STEP   = SETTLE + NS + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             fb_i = 1'b0;
    logic             strobe_en_o;
    logic [TAP_W-1:0] dly_o;
    logic             done_o;
    logic             fail_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int sc     = 0;
    int thr    = 0;

    // reference model state
    int m_ph = 0;      // 0 idle 1 settle 2 sample 3 eval 4 done 5 fail
    int m_cnt, m_ones, m_dly, m_prev;
    bit m_en, m_done, m_fail;

    wlvl_edge_search #(.TAP_W(TAP_W), .SETTLE_CYC(SETTLE), .N_SAMP(NS), .VOTE_MIN(VMIN)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fb_i        (fb_i),
        .strobe_en_o (strobe_en_o),
        .dly_o       (dly_o),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_ones = 0; m_dly = 0; m_prev = -1;
            m_en = 0; m_done = 0; m_fail = 0;
        end else begin
            case (m_ph)
                0, 4, 5: begin
                    if (m_ph != 0) m_en = 0;
                    if (start_i) begin
                        m_ph = 1; m_en = 1; m_done = 0; m_fail = 0;
                        m_dly = 0; m_prev = -1; m_cnt = 0;
                    end
                end
                1: begin
                    m_cnt++;
                    if (m_cnt == SETTLE) begin m_ph = 2; m_cnt = 0; m_ones = 0; end
                end
                2: begin
                    m_ones += int'(fb_i);
                    m_cnt++;
                    if (m_cnt == NS) m_ph = 3;
                end
                default: begin
                    if (m_prev == 0 && m_ones >= VMIN) begin
                        m_ph = 4; m_done = 1;
                    end else if (m_dly == (1 << TAP_W) - 1) begin
                        m_ph = 5; m_fail = 1; m_dly = 0;
                    end else begin
                        m_prev = (m_ones >= VMIN) ? 1 : 0;
                        m_dly++; m_ph = 1; m_cnt = 0;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison and feedback generation
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(int'(dly_o) == m_dly, "R2 delay tap", int'(dly_o), m_dly);
            check(strobe_en_o == m_en, "R1/R6 strobe enable", int'(strobe_en_o), int'(m_en));
            check(done_o == m_done, "R4 done", int'(done_o), int'(m_done));
            check(fail_o == m_fail, "R5 fail", int'(fail_o), int'(m_fail));
        end
        case (sc)
            0: fb_i <= (int'(dly_o) >= thr);
            1: fb_i <= (dly_o < 5) || (dly_o >= 20);
            2: fb_i <= (dly_o < 30) ? 8'b1010_0101 >> (cyc % 8) : 8'b1011_0101 >> (cyc % 8);
            3: fb_i <= 1'b0;
            default: fb_i <= (int'(dly_o) < thr) ? 8'b0000_0011 >> (cyc % 8)
                                                 : 8'b1111_1110 >> (cyc % 8);
        endcase
    end

    task automatic run_search(input int sc_i, input int thr_i, input int pulse_at, output int lat);
        sc  = sc_i;
        thr = thr_i;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && !fail_o && lat < 5000) begin
            @(negedge clk);
            lat++;
            start_i = (lat == pulse_at);
        end
        start_i = 1'b0;
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R8: outputs quiet in reset
        check(!strobe_en_o && dly_o == 0 && !done_o && !fail_o, "R8 reset state",
              int'({strobe_en_o, done_o, fail_o}) + int'(dly_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!strobe_en_o, "R1 idle strobe", int'(strobe_en_o), 0);

        // R2/R4: clean edge at tap 10, step timing
        run_search(0, 10, 0, lat);
        check(done_o && dly_o == 10, "R4 clean edge tap", int'(dly_o), 10);
        check(lat == STEP * 11 + 1, "R2 step timing", lat, STEP * 11 + 1);
        @(negedge clk);
        check(done_o && !strobe_en_o, "R6 strobe stops after done", int'(strobe_en_o), 0);

        // R7: start pulse mid-search ignored
        run_search(0, 12, 40, lat);
        check(done_o && dly_o == 12, "R7 mid-search start ignored", int'(dly_o), 12);
        check(lat == STEP * 13 + 1, "R7 no restart timing", lat, STEP * 13 + 1);

        // R4: high at start, fall, rise again
        run_search(1, 0, 0, lat);
        check(done_o && dly_o == 20, "R4 only a 0-to-1 rise counts", int'(dly_o), 20);

        // R3: 4 of 8 reads 0, 5 of 8 reads 1
        run_search(2, 0, 0, lat);
        check(done_o && dly_o == 30, "R3 vote threshold", int'(dly_o), 30);

        // R3: noisy feedback around tap 45
        run_search(4, 45, 0, lat);
        check(done_o && dly_o == 45, "R3 noisy majority", int'(dly_o), 45);

        // R4: edge on the last tap still found
        run_search(0, 127, 0, lat);
        check(done_o && !fail_o && dly_o == 127, "R4 edge at max tap", int'(dly_o), 127);

        // R5: never rising
        run_search(3, 0, 0, lat);
        check(fail_o && !done_o && dly_o == 0, "R5 fail leaves tap 0", int'(dly_o), 0);
        check(lat == STEP * 128 + 1, "R5 fail after full sweep", lat, STEP * 128 + 1);
        @(negedge clk);
        check(!strobe_en_o, "R6 strobe stops after fail", int'(strobe_en_o), 0);

        // R4: high from tap 0 has no prior low step
        run_search(0, 0, 0, lat);
        check(fail_o && !done_o, "R4 high at tap 0 not an edge", int'(fail_o), 1);

        // R7: restart from failed state clears fail
        sc = 0; thr = 3;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!fail_o && !done_o && strobe_en_o && dly_o == 0, "R7 restart clears outcome",
              int'({fail_o, done_o, strobe_en_o}), 1);
        repeat (STEP * 4 + 2) @(negedge clk);
        check(done_o && dly_o == 3, "R7 restarted search result", int'(dly_o), 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 60000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule